// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

This block lets a slave card on an asynchronous backplane request service from an interrupt handler. When the local source raises its request, the block pulls low one of seven active-low interrupt level lines. The line it pulls is chosen by a configured level from 1 to 7, and that level is captured when the line is raised. A configured level of 0 raises no line at all.

An interrupt handler answers with an acknowledge cycle. This is a single read with the acknowledge line low, and the level being served is encoded on address bits 3:1. The block sits in a daisy chain, with a chain input from the card upstream and a chain output to the card downstream.

If its own raised level matches the code on address bits 3:1, the block keeps the chain output high. It places its 8-bit vector on the data lines and then asserts data acknowledge. Once it has answered, it drops its level line. Otherwise it forwards the chain signal to the next card for as long as the address strobe stays asserted. Because the first matching card in the chain absorbs the acknowledge, a card nearer the handler is served before a farther card on the same level.

All bus inputs are assumed already synchronized to `clk`.

Top module: `irq_chain_requester`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it, all seven `irq_n` bits are high, `iackout_n` is high, `dtack_n` is high and `vec_oe` is 0.
- R2: With `src_req` high and `cfg_level` = L in 1..7, the cycle after the request is seen `irq_n` has exactly bit L low. In `irq_n[7:1]`, index L is level L. With `cfg_level` = 0, no line is driven. At most one line is ever low.
- R3: When `src_req` falls, the level line returns high on the next cycle.
- R4: An acknowledge cycle is one with `iack_n`, `as_n` and `iackin_n` all low. When such a cycle has `ack_lvl` equal to the raised level, the block does the following. One cycle later `vec_oe` is 1 and `vec_out[7:0]` holds `cfg_vector`. On the following cycle, if any `ds_n` bit is low, `dtack_n` goes low. Throughout, `iackout_n` stays high.
- R5: The cycle after both `ds_n` bits are high during acknowledge, `dtack_n` returns high and `vec_oe` returns 0.
- R6: The level line is high while `dtack_n` is low. If `src_req` is still high, the line is driven again on the cycle after the block returns idle. The block returns idle when the strobes are released.
- R7: When an acknowledge cycle has no match, the block forwards the chain. No match means no line is raised, or `ack_lvl` differs from the raised level. `iackout_n` goes low one cycle after the cycle is seen. It returns high one cycle after `as_n` or `iackin_n` goes high. `dtack_n` stays high.
- R8: With `iackin_n` high, an acknowledge cycle at the matching level is not answered. `dtack_n`, `vec_oe` and `iackout_n` stay inactive, and the level line stays low.
- R9: Strobe activity with `iack_n` high is not an acknowledge. `iackout_n` and `dtack_n` stay high.
- R10: Suppose two blocks are chained with equal pending levels. The first acknowledge is answered by the upstream block while the downstream block stays silent. Once the upstream request is gone, the next acknowledge passes through the upstream block and is answered downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 1 | Local service request, level-sensitive |
| cfg_level | input | 3 | Interrupt level to raise, 0 disables |
| cfg_vector | input | 8 | Vector returned on acknowledge |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 2 | Data strobes, active low |
| iack_n | input | 1 | Acknowledge-cycle indicator, active low |
| ack_lvl | input | 3 | Address bits 3:1, level being acknowledged |
| iackin_n | input | 1 | Chain input from upstream, active low |
| irq_n | output | 7 | Level lines, index 1..7, active low |
| iackout_n | output | 1 | Chain output to downstream, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| vec_out | output | 8 | Vector onto data bits 7:0 |
| vec_oe | output | 1 | Drive enable for `vec_out` |

## Verification
The assertions check, on every cycle, the protocol orderings that are local to one block:
- at most one level line is low;
- the vector is driven the cycle before acknowledge falls;
- acknowledge and a forwarded chain signal are never both active;
- the chain output only follows a strobed, low chain input;
- the level line is dropped while acknowledged;
- acknowledge releases after the strobes rise.

The bench scenarios are what show the outcome of each acknowledge. They cover which cycles are answered and which are passed on, the re-raise after the cycle ends, the ignored non-acknowledge cycles, and the ordering between two chained requesters on the same level.

// File: rtl/irq_chain_requester.sv
module irq_chain_requester #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  parameter int NLVL  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_req,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [VEC_W-1:0] cfg_vector,
  input  logic             as_n,
  input  logic [1:0]       ds_n,
  input  logic             iack_n,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic             iackin_n,
  output logic [NLVL:1]    irq_n,
  output logic             iackout_n,
  output logic             dtack_n,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_oe
);

  typedef enum logic [2:0] {S_IDLE, S_PASS, S_DRIVE, S_ACK, S_TAIL} st_t;

  st_t              st;
  logic             raised;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;

  wire ack_cyc  = !iack_n && !as_n && !iackin_n;
  wire ds_any   = !(&ds_n);
  wire hit      = raised && (ack_lvl == lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      vec_q <= '0;
    end else begin
      case (st)
        S_IDLE:  if (ack_cyc) begin
                   st <= hit ? S_DRIVE : S_PASS;
                   vec_q <= cfg_vector;
                 end
        S_PASS:  if (as_n || iackin_n) st <= S_IDLE;
        S_DRIVE: if (as_n && !ds_any) st <= S_IDLE;
                 else if (ds_any) st <= S_ACK;
        S_ACK:   if (!ds_any) st <= as_n ? S_IDLE : S_TAIL;
        S_TAIL:  if (as_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised <= 1'b0;
      lvl_q  <= '0;
    end else if (!src_req) begin
      raised <= 1'b0;
    end else if (st == S_DRIVE && ds_any) begin
      raised <= 1'b0;
    end else if (st == S_IDLE && !raised && cfg_level != '0) begin
      raised <= 1'b1;
      lvl_q  <= cfg_level;
    end
  end

  for (genvar i = 1; i <= NLVL; i++) begin : g_line
    assign irq_n[i] = !(raised && lvl_q == LVL_W'(i));
  end

  assign iackout_n = (st != S_PASS);
  assign dtack_n   = (st != S_ACK);
  assign vec_oe    = (st == S_DRIVE) || (st == S_ACK);
  assign vec_out   = vec_oe ? vec_q : '0;

  // R2
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));

  // R4
  vec_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(vec_oe));

  // R4
  ack_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !iackout_n));

  // R7
  fwd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iackout_n) |-> $past(!iackin_n && !as_n && !iack_n));

  // R6
  line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (&irq_n));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && (&ds_n)) |=> (dtack_n && !vec_oe));

endmodule

// File: tb/tb_irq_chain_requester.sv
module tb_irq_chain_requester;
  logic clk = 0;
  logic rst_n = 0;
  logic src_req = 0, req2 = 0;
  logic [2:0] cfg_level = 0, cfg2 = 3'd3;
  logic [7:0] cfg_vector = 0, vec2 = 8'h5C;
  logic as_n = 1, iack_n = 1, iackin_n = 1;
  logic [1:0] ds_n = 2'b11;
  logic [2:0] ack_lvl = 0;
  logic [7:1] irq_n, irq2_n;
  logic iackout_n, dtack_n, vec_oe, iackout2_n, dtack2_n, vec2_oe;
  logic [7:0] vec_out, vec2_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_chain_requester dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_level(cfg_level),
    .cfg_vector(cfg_vector), .as_n(as_n), .ds_n(ds_n), .iack_n(iack_n),
    .ack_lvl(ack_lvl), .iackin_n(iackin_n), .irq_n(irq_n),
    .iackout_n(iackout_n), .dtack_n(dtack_n), .vec_out(vec_out), .vec_oe(vec_oe));

  irq_chain_requester dut2 (
    .clk(clk), .rst_n(rst_n), .src_req(req2), .cfg_level(cfg2),
    .cfg_vector(vec2), .as_n(as_n), .ds_n(ds_n), .iack_n(iack_n),
    .ack_lvl(ack_lvl), .iackin_n(iackout_n), .irq_n(irq2_n),
    .iackout_n(iackout2_n), .dtack_n(dtack2_n), .vec_out(vec2_out), .vec_oe(vec2_oe));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:1] line(input int l);
    return (l == 0) ? 7'h7F : ~(7'd1 << (l - 1));
  endfunction

  task automatic bus_idle();
    as_n = 1; ds_n = 2'b11; iack_n = 1; iackin_n = 1;
    step(2);
  endtask

  task automatic start_ack(input logic [2:0] l);
    iack_n = 0; ack_lvl = l; iackin_n = 0; as_n = 0; ds_n = 2'b00;
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 irq", 16'(irq_n), 16'h7F);
    chk("R1 iackout", 16'(iackout_n), 16'h1);
    chk("R1 dtack", 16'(dtack_n), 16'h1);
    chk("R1 oe", 16'(vec_oe), 16'h0);
    rst_n = 1;
    step(1);
    chk("R1 irq after", 16'(irq_n), 16'h7F);
  endtask

  task automatic t_raise();
    cfg_level = 0; src_req = 1;
    step(2);
    chk("R2 level0", 16'(irq_n), 16'h7F);
    src_req = 0; step(1);
    cfg_level = 5; src_req = 1;
    step(1);
    chk("R2 level5", 16'(irq_n), 16'(line(5)));
    src_req = 0;
    step(1);
    chk("R3 withdraw", 16'(irq_n), 16'h7F);
    cfg_level = 7; src_req = 1;
    step(1);
    chk("R2 level7", 16'(irq_n), 16'(line(7)));
    src_req = 0; step(1);
  endtask

  task automatic t_match();
    cfg_level = 5; cfg_vector = 8'hA7; src_req = 1;
    step(1);
    start_ack(3'd5);
    step(1);
    chk("R4 oe", 16'(vec_oe), 16'h1);
    chk("R4 vector", 16'(vec_out), 16'h00A7);
    chk("R4 dtack wait", 16'(dtack_n), 16'h1);
    chk("R4 no fwd", 16'(iackout_n), 16'h1);
    step(1);
    chk("R4 dtack", 16'(dtack_n), 16'h0);
    chk("R6 line off", 16'(irq_n), 16'h7F);
    ds_n = 2'b11; as_n = 1;
    step(1);
    chk("R5 dtack rel", 16'(dtack_n), 16'h1);
    chk("R5 oe rel", 16'(vec_oe), 16'h0);
    step(1);
    chk("R6 reraise", 16'(irq_n), 16'(line(5)));
    src_req = 0;
    bus_idle();
  endtask

  task automatic t_pass_level();
    cfg_level = 2; src_req = 1;
    step(1);
    start_ack(3'd6);
    step(1);
    chk("R7 fwd", 16'(iackout_n), 16'h0);
    chk("R7 no dtack", 16'(dtack_n), 16'h1);
    chk("R7 line kept", 16'(irq_n), 16'(line(2)));
    as_n = 1; ds_n = 2'b11;
    step(1);
    chk("R7 fwd end", 16'(iackout_n), 16'h1);
    src_req = 0;
    bus_idle();
    start_ack(3'd2);
    step(1);
    chk("R7 idle fwd", 16'(iackout_n), 16'h0);
    iackin_n = 1;
    step(1);
    chk("R7 iackin rel", 16'(iackout_n), 16'h1);
    bus_idle();
  endtask

  task automatic t_no_iackin();
    cfg_level = 4; src_req = 1;
    step(1);
    start_ack(3'd4); iackin_n = 1;
    step(2);
    chk("R8 dtack", 16'(dtack_n), 16'h1);
    chk("R8 oe", 16'(vec_oe), 16'h0);
    chk("R8 iackout", 16'(iackout_n), 16'h1);
    chk("R8 line", 16'(irq_n), 16'(line(4)));
    bus_idle();
    src_req = 0; step(1);
  endtask

  task automatic t_non_iack();
    cfg_level = 1; src_req = 1;
    step(1);
    start_ack(3'd1); iack_n = 1;
    step(3);
    chk("R9 iackout", 16'(iackout_n), 16'h1);
    chk("R9 dtack", 16'(dtack_n), 16'h1);
    chk("R9 line", 16'(irq_n), 16'(line(1)));
    bus_idle();
    src_req = 0; step(1);
  endtask

  task automatic t_chain();
    cfg_level = 3; cfg_vector = 8'h11; src_req = 1; req2 = 1;
    step(1);
    start_ack(3'd3);
    step(2);
    chk("R10 up dtack", 16'(dtack_n), 16'h0);
    chk("R10 up vec", 16'(vec_out), 16'h0011);
    chk("R10 down quiet", 16'(dtack2_n), 16'h1);
    chk("R10 down oe", 16'(vec2_oe), 16'h0);
    as_n = 1; ds_n = 2'b11; src_req = 0;
    bus_idle();
    start_ack(3'd3);
    step(1);
    chk("R10 pass", 16'(iackout_n), 16'h0);
    step(1);
    chk("R10 down vec", 16'(vec2_out), 16'h005C);
    step(1);
    chk("R10 down dtack", 16'(dtack2_n), 16'h0);
    chk("R10 up quiet", 16'(dtack_n), 16'h1);
    as_n = 1; ds_n = 2'b11; req2 = 0;
    bus_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_raise();
    t_match();
    t_pass_level();
    t_no_iackin();
    t_non_iack();
    t_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule